// File: doc/BRIEF.md
# Pipelined Natural Logarithm Unit

This block turns an unsigned 16-bit integer `t` into a 16-bit code proportional to ln(t). It uses hyperbolic CORDIC in vectoring mode, fully unrolled into a register pipeline. The starting vector is x = t+1 and y = t-1, and the angle accumulator starts at zero. Every stage pushes y toward zero using only shifts and add/subtract operations, and adds or removes a fixed angle constant. Once y has been nulled, the accumulator holds atanh((t-1)/(t+1)), which equals half of ln(t).

Six range-widening stages come first, with indices -5 through 0. Each of these scales the opposite operand by (1 - 2^(i-2)), so that ratios y/x close to 1 still converge. The usual 2^-i stages follow, with indices 1 through 16, and index 4 is run twice to close the convergence gap that the plain sequence leaves. The doubled angle is saturated into 16 bits on a scale where 0xFFFF stands for ln(65535).

The block takes one sample per clock through a valid/data pair and returns results in order on a valid/data pair after a fixed latency. The block has no state machine. Its only control is a valid bit that travels with each sample through the pipeline. Input t = 0 is outside the defined range.

Top module: `log_cordic_ln`

## Requirements
- R1: For every input 1 ≤ t ≤ 65535, `out_ln` is within ±16 LSB of round(ln(t) × 65535 / 11.0903).
- R2: The reference inputs produce these codes within ±16 LSB: 13 → 0x3B32, 255 → 0x7FEA, 1023 → 0x9FFE, 12001 → 0xD8D2, 64555 → 0xFFA6.
- R3: An input of t = 1 yields a code no larger than 16 and never a wrapped value near 0xFFFF.
- R4: The output is twice the final angle, clamped. A negative angle gives 0, and anything above 65535 gives 0xFFFF. An input of t = 65535 yields at least 0xFFF0.
- R5: A sample taken on rising edge E appears on `out_ln`, with `out_valid` high, right after rising edge E+22. This is a latency of 23 clock cycles.
- R6: A new sample is accepted on every cycle. Results leave in input order, and every cycle without an input sample becomes a cycle with `out_valid` low, 23 cycles later.
- R7: A synchronous `rst` drops every sample in flight. `out_valid` is low in the cycle after reset and stays low until a new sample has crossed the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the valid bits only |
| in_valid | input | 1 | Input sample present this cycle |
| in_t | input | 16 | Unsigned argument t, 1 to 65535 |
| out_valid | output | 1 | Result present this cycle |
| out_ln | output | 16 | Scaled logarithm, 0xFFFF ≙ ln(65535) |

## Verification
A small vector table streams back to back. It covers t = 1, small integers where the starting ratio y/x is far from 1, mid-range powers of two, the five reference points, and the top of the range, where only the widening stages can reach convergence. A run of several hundred random arguments then checks the value across the full range, which exposes a wrong angle constant, a wrong shift or a wrong direction decision in any single stage. Sparse valid patterns and a lone pulse separate a latency that is off by one from a valid bit that is lost or duplicated. A reset in the middle of a stream shows that samples in flight are discarded rather than released later.

// File: rtl/log_cordic_pkg.sv
package log_cordic_pkg;

    localparam int ANG_W = 16;

    // Hard-wired hyperbolic angle per stage index, about 5909 LSB per radian.
    function automatic logic [ANG_W-1:0] angle_code(input int idx);
        logic [ANG_W-1:0] c;
        case (idx)
            -5:      c = 16'h3FF4;
            -4:      c = 16'h37E9;
            -3:      c = 16'h2FD1;
            -2:      c = 16'h27A2;
            -1:      c = 16'h1F41;
            0:       c = 16'h1675;
            1:       c = 16'h0CAE;
            2:       c = 16'h05E5;
            3:       c = 16'h02E7;
            4:       c = 16'h0172;
            5:       c = 16'h00B9;
            6:       c = 16'h005C;
            7:       c = 16'h002E;
            8:       c = 16'h0017;
            9:       c = 16'h000B;
            10:      c = 16'h0006;
            11:      c = 16'h0003;
            12:      c = 16'h0001;
            default: c = 16'h0000;
        endcase
        return c;
    endfunction

    // Maps the physical stage position k to its iteration index:
    // first..0, then 1..last with rep_idx issued twice.
    function automatic int stage_index(input int k, input int first, input int rep_idx);
        int n_neg;
        int p;
        n_neg = 1 - first;
        if (k < n_neg) begin
            return first + k;
        end
        p = k - n_neg + 1;
        return (p <= rep_idx) ? p : p - 1;
    endfunction

    function automatic int stage_shift(input int idx);
        return (idx <= 0) ? (2 - idx) : idx;
    endfunction

endpackage

// File: rtl/log_cordic_prep.sv
module log_cordic_prep #(
    parameter int IN_W   = 16,
    parameter int DP_W   = 48,
    parameter int FRAC_W = 28
) (
    input  logic [IN_W-1:0]        arg_t,
    output logic signed [DP_W-1:0] x_start,
    output logic signed [DP_W-1:0] y_start
);

    logic [DP_W-1:0] t_wide;

    always_comb begin
        t_wide  = DP_W'(arg_t);
        x_start = $signed((t_wide + DP_W'(1)) << FRAC_W);
        y_start = $signed((t_wide - DP_W'(1)) << FRAC_W);
    end

endmodule

// File: rtl/log_cordic_stage.sv
module log_cordic_stage
    import log_cordic_pkg::*;
#(
    parameter int DP_W = 48,
    parameter int IDX  = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   v_i,
    input  logic signed [DP_W-1:0] x_i,
    input  logic signed [DP_W-1:0] y_i,
    input  logic signed [DP_W-1:0] z_i,
    output logic                   v_o,
    output logic signed [DP_W-1:0] x_o,
    output logic signed [DP_W-1:0] y_o,
    output logic signed [DP_W-1:0] z_o
);

    localparam int                     SH  = stage_shift(IDX);
    localparam logic signed [DP_W-1:0] ANG = $signed(DP_W'(angle_code(IDX)));

    logic signed [DP_W-1:0] fx, fy;
    logic signed [DP_W-1:0] x_nx, y_nx, z_nx;
    logic                   y_neg;

    generate
        if (IDX <= 0) begin : g_widen
            // operand * (1 - 2^(IDX-2))
            always_comb begin
                fx = x_i - (x_i >>> SH);
                fy = y_i - (y_i >>> SH);
            end
        end else begin : g_plain
            // operand * 2^-IDX
            always_comb begin
                fx = x_i >>> SH;
                fy = y_i >>> SH;
            end
        end
    endgenerate

    always_comb begin
        y_neg = y_i[DP_W-1];
        if (y_neg) begin
            x_nx = x_i + fy;
            y_nx = y_i + fx;
            z_nx = z_i - ANG;
        end else begin
            x_nx = x_i - fy;
            y_nx = y_i - fx;
            z_nx = z_i + ANG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o <= 1'b0;
        end else begin
            v_o <= v_i;
        end
    end

    always_ff @(posedge clk) begin
        x_o <= x_nx;
        y_o <= y_nx;
        z_o <= z_nx;
    end

    // R1: the vector stays on the right-hand branch of the hyperbola
    p_x_positive_r1: assert property (@(posedge clk) disable iff (rst)
        v_o |-> (x_o > 0));

endmodule

// File: rtl/log_cordic_scale.sv
module log_cordic_scale #(
    parameter int DP_W  = 48,
    parameter int OUT_W = 16
) (
    input  logic signed [DP_W-1:0] z_fin,
    output logic [OUT_W-1:0]       code
);

    localparam logic signed [DP_W:0] MAX_CODE =
        $signed({{(DP_W+1-OUT_W){1'b0}}, {OUT_W{1'b1}}});

    logic signed [DP_W:0] twice;

    always_comb begin
        twice = $signed({z_fin, 1'b0});
        if (twice < 0) begin
            code = '0;
        end else if (twice > MAX_CODE) begin
            code = '1;
        end else begin
            code = twice[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/log_cordic_ln.sv
module log_cordic_ln
    import log_cordic_pkg::*;
#(
    parameter int IN_W       = 16,
    parameter int OUT_W      = 16,
    parameter int DP_W       = 48,
    parameter int FRAC_W     = 28,
    parameter int FIRST_IDX  = -5,
    parameter int LAST_IDX   = 16,
    parameter int REPEAT_IDX = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_t,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_ln
);

    localparam int N_NEG = 1 - FIRST_IDX;
    localparam int N_STG = N_NEG + LAST_IDX + 1;

    logic                   vs [N_STG+1];
    logic signed [DP_W-1:0] xs [N_STG+1];
    logic signed [DP_W-1:0] ys [N_STG+1];
    logic signed [DP_W-1:0] zs [N_STG+1];

    log_cordic_prep #(
        .IN_W  (IN_W),
        .DP_W  (DP_W),
        .FRAC_W(FRAC_W)
    ) u_prep (
        .arg_t  (in_t),
        .x_start(xs[0]),
        .y_start(ys[0])
    );

    always_comb begin
        vs[0] = in_valid;
        zs[0] = '0;
    end

    generate
        for (genvar k = 0; k < N_STG; k++) begin : g_stage
            localparam int IDX_K = stage_index(k, FIRST_IDX, REPEAT_IDX);
            log_cordic_stage #(
                .DP_W(DP_W),
                .IDX (IDX_K)
            ) u_stage (
                .clk(clk),
                .rst(rst),
                .v_i(vs[k]),
                .x_i(xs[k]),
                .y_i(ys[k]),
                .z_i(zs[k]),
                .v_o(vs[k+1]),
                .x_o(xs[k+1]),
                .y_o(ys[k+1]),
                .z_o(zs[k+1])
            );
        end
    endgenerate

    log_cordic_scale #(
        .DP_W (DP_W),
        .OUT_W(OUT_W)
    ) u_scale (
        .z_fin(zs[N_STG]),
        .code (out_ln)
    );

    assign out_valid = vs[N_STG];

    logic signed [DP_W-1:0] y_mag;
    always_comb begin
        y_mag = ys[N_STG][DP_W-1] ? -ys[N_STG] : ys[N_STG];
    end

    // R7: a reset cycle leaves nothing valid behind it
    p_reset_flush_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R1: vectoring has nulled y relative to x at the last stage
    p_residual_small_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (y_mag <= (xs[N_STG] >>> 10)));

    // R1: the final half-angle stays within the range of 1..65535
    p_angle_range_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (zs[N_STG] >= -64 && zs[N_STG] <= 32832));

    // R4: a negative final angle never escapes as a wrapped code
    p_clamp_low_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zs[N_STG] < 0) |-> (out_ln == '0));

endmodule

// File: tb/test_log_cordic_ln.sv
`timescale 1ns/1ps
module test_log_cordic_ln;

    localparam int  LAT   = 23;
    localparam int  TOL   = 16;
    localparam time CLK_P = 4ns;
    localparam int  MAXN  = 400;

    localparam logic [15:0] VEC_T [12] = '{
        16'd1, 16'd2, 16'd3, 16'd13, 16'd100, 16'd255,
        16'd1023, 16'd12001, 16'd32768, 16'd64555, 16'd65535, 16'd7
    };
    localparam logic [31:0] REF_PAIR [5] = '{
        {16'd13,    16'h3B32},
        {16'd255,   16'h7FEA},
        {16'd1023,  16'h9FFE},
        {16'd12001, 16'hD8D2},
        {16'd64555, 16'hFFA6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_t = 16'd1;
    logic        out_valid;
    logic [15:0] out_ln;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] st_t [MAXN];
    logic        st_v [MAXN];
    int          st_n = 0;

    always #(CLK_P/2) clk = ~clk;

    log_cordic_ln i_log_cordic_ln (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_t     (in_t),
        .out_valid(out_valid),
        .out_ln   (out_ln)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expected_code(input int t);
        real v;
        int  r;
        v = $ln(real'(t)) * 65535.0 / 11.0903;
        r = int'(v);
        if (r > 65535) r = 65535;
        if (r < 0) r = 0;
        return r;
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic check_entry(input int k);
        int t;
        int e;
        t = int'(st_t[k]);
        if (st_v[k]) begin
            check(out_valid === 1'b1, "R6 out_valid for sample", int'(out_valid), 1);
            e = expected_code(t);
            check(absdiff(int'(out_ln), e) <= TOL, $sformatf("R1 t=%0d", t), int'(out_ln), e);
            if (t == 1)
                check(out_ln <= 16'd16, "R3 t=1 near zero", int'(out_ln), 0);
            if (t == 65535)
                check(out_ln >= 16'hFFF0, "R4 top of range no wrap", int'(out_ln), 65535);
            for (int r = 0; r < 5; r++) begin
                if (REF_PAIR[r][31:16] == st_t[k])
                    check(absdiff(int'(out_ln), int'(REF_PAIR[r][15:0])) <= TOL,
                          $sformatf("R2 reference t=%0d", t), int'(out_ln), int'(REF_PAIR[r][15:0]));
            end
        end else begin
            check(out_valid === 1'b0, "R6 gap preserved", int'(out_valid), 0);
        end
    endtask

    // Called at a falling edge; drives one entry per cycle and checks LAT cycles later.
    task automatic run_stream();
        fork
            begin
                for (int k = 0; k < st_n; k++) begin
                    in_valid = st_v[k];
                    in_t     = st_t[k];
                    @(negedge clk);
                end
                in_valid = 1'b0;
            end
            begin
                repeat (LAT) @(negedge clk);
                for (int k = 0; k < st_n; k++) begin
                    check_entry(k);
                    @(negedge clk);
                end
            end
        join
    endtask

    initial begin
        #(CLK_P * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R5 actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int cnt;
        bit seen;

        // Reset state (R7)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R7 out_valid low in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R7 out_valid low after reset", int'(out_valid), 0);

        // Table walk, back to back (R1 R2 R3 R4 R6)
        st_n = 12;
        for (int k = 0; k < 12; k++) begin
            st_t[k] = VEC_T[k];
            st_v[k] = 1'b1;
        end
        run_stream();

        // Sparse valid pattern (R6)
        st_n = 10;
        for (int k = 0; k < 10; k++) begin
            st_t[k] = 16'(1000 + 517 * k);
            st_v[k] = ((k % 3) != 1);
        end
        run_stream();

        // Random arguments across the range (R1)
        st_n = 300;
        for (int k = 0; k < 300; k++) begin
            st_t[k] = 16'($urandom_range(65535, 1));
            st_v[k] = 1'b1;
        end
        run_stream();

        // Exact latency of a lone sample (R5)
        repeat (LAT + 2) @(negedge clk);
        in_valid = 1'b1;
        in_t     = 16'd4096;
        @(negedge clk);
        in_valid = 1'b0;
        cnt  = 1;
        seen = 1'b0;
        while (!seen && cnt < 40) begin
            if (out_valid) seen = 1'b1;
            else begin
                cnt++;
                @(negedge clk);
            end
        end
        check(cnt == LAT, "R5 latency in cycles", cnt, LAT);
        check(absdiff(int'(out_ln), expected_code(4096)) <= TOL, "R5 value at latency",
              int'(out_ln), expected_code(4096));
        @(negedge clk);
        check(out_valid === 1'b0, "R5 single cycle result", int'(out_valid), 0);

        // Reset in the middle of a stream (R7)
        repeat (LAT + 2) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            in_valid = 1'b1;
            in_t     = 16'(50 + k);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < LAT + 4; k++) begin
            check(out_valid === 1'b0, "R7 in-flight samples dropped", int'(out_valid), 0);
            @(negedge clk);
        end

        // Recovery after reset (R7)
        st_n = 2;
        st_t[0] = 16'd20000; st_v[0] = 1'b1;
        st_t[1] = 16'd2;     st_v[1] = 1'b1;
        run_stream();

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule